// File: doc/BRIEF.md
# Dual Missed-Frame Diagnostic Counter

This block is a receive-path diagnostic status word. It keeps two separate tallies of frames that never reach the host. The first counts frames that the receive DMA throws away because no host receive buffer is free. The second counts frames lost to FIFO or MAC overflow, together with runt frames, which are frames shorter than 64 bytes. Both tallies share one 32-bit word. Each has its own sticky wrap flag.

Drop events arrive as single-cycle pulses. A CPU reads the word through a one-signal read strobe. The value it reads appears on a registered data output, and the read clears every field. Software polls the word now and then. The wrap flags tell it whether a counter has passed its limit since the last poll.

Top module: `drop_stat_reg`

## Requirements
- R1: After synchronous reset, `rd_data` is zero and the first read returns zero.
- R2: Each cycle with `buf_miss` high adds one to the buffer-unavailable count. This count sits at bits [BUF_W-1:0].
- R3: Each cycle with `rx_ovf` or `runt_drop` high adds exactly one to the overflow count. This count sits at bits [BUF_W+OVF_W:BUF_W+1]. A cycle with both pulses high still adds only one.
- R4: If the buffer-unavailable count is at its maximum and receives an increment, it wraps to zero in that same cycle. Its sticky flag at bit BUF_W is set at the same time and stays set until a read.
- R5: If the overflow count is at its maximum and receives an increment, it wraps to zero. Its sticky flag at bit BUF_W+OVF_W+1 is set and stays set until a read.
- R6: A cycle with `rd_en` high loads `rd_data` with the word as it stood before that clock edge. The value is visible from the next cycle. All counts and flags are cleared.
- R7: If an increment and a read occur in the same cycle, the read returns the old value. The affected count then holds 1.
- R8: Both counts may increment in the same cycle. Neither disturbs the other.
- R9: Bits above BUF_W+OVF_W+1 always read as zero.
- R10: `rd_data` holds its value in every cycle without a read, whatever drop pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_miss | input | 1 | One-cycle pulse: a frame was discarded because no host buffer was free |
| rx_ovf | input | 1 | One-cycle pulse: a frame was lost to FIFO or MAC overflow |
| runt_drop | input | 1 | One-cycle pulse: a runt frame was dropped |
| rd_en | input | 1 | Read strobe; captures the word and clears it |
| rd_data | output | REG_W | Registered read data |

## Verification
The bench builds the block with BUF_W=5 and OVF_W=3 and keeps REG_W at 32. With these widths the buffer-unavailable count wraps after 32 pulses and the overflow count after 8. Both wrap flags, the wrap-to-zero behaviour and the zero reserved bits above bit 9 can therefore be reached with short directed pulse trains. The field placement is derived from the parameters, so the same packing logic is exercised as with the default 16/11 layout.

// File: rtl/drop_stat_pkg.sv
package drop_stat_pkg;
  // Default field widths of the status word.
  localparam int unsigned DEF_BUF_W = 16;
  localparam int unsigned DEF_OVF_W = 11;
  localparam int unsigned DEF_REG_W = 32;

  // Number of status bits used by two counts plus two flags.
  function automatic int unsigned used_bits(input int unsigned bw, input int unsigned ow);
    return bw + ow + 2;
  endfunction
endpackage

// File: rtl/drop_evt_merge.sv
module drop_evt_merge #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] evt,
  output logic         any
);
  logic [N:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign chain[i+1] = chain[i] | evt[i];
  end
  assign any = chain[N];
endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         wrapped
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      wrapped <= 1'b0;
    end else if (clr) begin
      // Clearing read: an increment in the same cycle survives as 1.
      cnt     <= inc ? ONE : '0;
      wrapped <= 1'b0;
    end else if (inc) begin
      cnt <= cnt + ONE;
      if (cnt == MAX) wrapped <= 1'b1;
    end
  end
endmodule

// File: rtl/drop_stat_snap.sv
module drop_stat_snap #(
  parameter int unsigned BUF_W = 16,
  parameter int unsigned OVF_W = 11,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [BUF_W-1:0] buf_cnt,
  input  logic             buf_wrap,
  input  logic [OVF_W-1:0] ovf_cnt,
  input  logic             ovf_wrap,
  output logic [REG_W-1:0] rd_data
);
  localparam int unsigned BUF_FLAG_POS = BUF_W;
  localparam int unsigned OVF_LSB      = BUF_W + 1;
  localparam int unsigned OVF_FLAG_POS = BUF_W + OVF_W + 1;

  logic [REG_W-1:0] word;

  always_comb begin
    word                     = '0;
    word[BUF_W-1:0]          = buf_cnt;
    word[BUF_FLAG_POS]       = buf_wrap;
    word[OVF_LSB +: OVF_W]   = ovf_cnt;
    word[OVF_FLAG_POS]       = ovf_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= word;
  end
endmodule

// File: rtl/drop_stat_reg.sv
module drop_stat_reg
  import drop_stat_pkg::*;
#(
  parameter int unsigned BUF_W = DEF_BUF_W,
  parameter int unsigned OVF_W = DEF_OVF_W,
  parameter int unsigned REG_W = DEF_REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             buf_miss,
  input  logic             rx_ovf,
  input  logic             runt_drop,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data
);
  localparam int unsigned USED = used_bits(BUF_W, OVF_W);

  initial begin
    if (USED > REG_W) $error("status fields do not fit in REG_W");
  end

  logic             ovf_any;
  logic [BUF_W-1:0] buf_cnt;
  logic             buf_wrap;
  logic [OVF_W-1:0] ovf_cnt;
  logic             ovf_wrap;

  drop_evt_merge #(.N(2)) u_merge (
    .evt ({runt_drop, rx_ovf}),
    .any (ovf_any)
  );

  drop_counter #(.W(BUF_W)) u_buf_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (buf_miss),
    .clr     (rd_en),
    .cnt     (buf_cnt),
    .wrapped (buf_wrap)
  );

  drop_counter #(.W(OVF_W)) u_ovf_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (ovf_any),
    .clr     (rd_en),
    .cnt     (ovf_cnt),
    .wrapped (ovf_wrap)
  );

  drop_stat_snap #(.BUF_W(BUF_W), .OVF_W(OVF_W), .REG_W(REG_W)) u_snap (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .buf_cnt  (buf_cnt),
    .buf_wrap (buf_wrap),
    .ovf_cnt  (ovf_cnt),
    .ovf_wrap (ovf_wrap),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/drop_stat_reg_chk.sv
module drop_stat_reg_chk #(
  parameter int unsigned BUF_W = 16,
  parameter int unsigned OVF_W = 11,
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             buf_miss,
  input logic             rx_ovf,
  input logic             runt_drop,
  input logic             rd_en,
  input logic [REG_W-1:0] rd_data,
  input logic [BUF_W-1:0] buf_cnt,
  input logic             buf_wrap,
  input logic [OVF_W-1:0] ovf_cnt,
  input logic             ovf_wrap
);
  localparam logic [BUF_W-1:0] BMAX = {BUF_W{1'b1}};
  localparam logic [OVF_W-1:0] OMAX = {OVF_W{1'b1}};
  localparam logic [BUF_W-1:0] BONE = BUF_W'(1);
  localparam logic [OVF_W-1:0] OONE = OVF_W'(1);
  localparam int unsigned TOP = BUF_W + OVF_W + 2;

  // R9
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data >> TOP) == '0);

  // R10
  a_r10_hold_no_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R2
  a_r2_buf_step: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && buf_miss && buf_cnt != BMAX) |=> buf_cnt == $past(buf_cnt) + BONE);

  // R3
  a_r3_ovf_step: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && (rx_ovf || runt_drop) && ovf_cnt != OMAX) |=> ovf_cnt == $past(ovf_cnt) + OONE);

  // R4
  a_r4_buf_wrap: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && buf_miss && buf_cnt == BMAX) |=> (buf_cnt == '0 && buf_wrap));

  a_r4_buf_sticky: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && buf_wrap) |=> buf_wrap);

  // R5
  a_r5_ovf_wrap: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && (rx_ovf || runt_drop) && ovf_cnt == OMAX) |=> (ovf_cnt == '0 && ovf_wrap));

  // R6
  a_r6_read_clears_flags: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (!buf_wrap && !ovf_wrap));

  // R7
  a_r7_read_with_inc: assert property (@(posedge clk) disable iff (rst)
    (rd_en && buf_miss) |=> buf_cnt == BONE);
endmodule

bind drop_stat_reg drop_stat_reg_chk #(.BUF_W(BUF_W), .OVF_W(OVF_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .buf_miss  (buf_miss),
  .rx_ovf    (rx_ovf),
  .runt_drop (runt_drop),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .buf_cnt   (buf_cnt),
  .buf_wrap  (buf_wrap),
  .ovf_cnt   (ovf_cnt),
  .ovf_wrap  (ovf_wrap)
);

// File: tb/drop_stat_reg_bench.sv
module drop_stat_reg_bench;
  localparam int unsigned BW = 5;
  localparam int unsigned OW = 3;
  localparam int unsigned RW = 32;
  localparam int unsigned BFLAG = BW;          // bit 5
  localparam int unsigned OLSB  = BW + 1;      // bit 6
  localparam int unsigned OFLAG = BW + OW + 1; // bit 9

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          buf_miss = 1'b0;
  logic          rx_ovf = 1'b0;
  logic          runt_drop = 1'b0;
  logic          rd_en = 1'b0;
  logic [RW-1:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  drop_stat_reg #(.BUF_W(BW), .OVF_W(OW), .REG_W(RW)) u_drop_stat_reg (
    .clk       (clk),
    .rst       (rst),
    .buf_miss  (buf_miss),
    .rx_ovf    (rx_ovf),
    .runt_drop (runt_drop),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
  );

  function automatic logic [RW-1:0] mk(input int b, input bit bf, input int o, input bit of);
    logic [RW-1:0] w;
    w = '0;
    w[BW-1:0]     = BW'(b);
    w[BFLAG]      = bf;
    w[OLSB +: OW] = OW'(o);
    w[OFLAG]      = of;
    return w;
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; entered and left at a falling edge.
  task automatic step(input bit b, input bit o, input bit r, input bit rd);
    buf_miss = b; rx_ovf = o; runt_drop = r; rd_en = rd;
    @(negedge clk);
    buf_miss = 0; rx_ovf = 0; runt_drop = 0; rd_en = 0;
  endtask

  task automatic do_read(output logic [RW-1:0] v);
    step(0, 0, 0, 1);
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [RW-1:0] v;
    check("R1 reset rd_data", rd_data, '0);
    do_read(v);
    check("R1 first read", v, '0);
  endtask

  task automatic t_buf_count;
    logic [RW-1:0] v;
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0);
    do_read(v);
    check("R2 buffer count 7", v, mk(7, 0, 0, 0));
    do_read(v);
    check("R6 cleared after read", v, '0);
  endtask

  task automatic t_ovf_runt;
    logic [RW-1:0] v;
    step(0, 1, 0, 0); step(0, 1, 0, 0);
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    step(0, 1, 1, 0);
    do_read(v);
    check("R3 overflow+runt count 5", v, mk(0, 0, 5, 0));
  endtask

  task automatic t_both;
    logic [RW-1:0] v;
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    do_read(v);
    check("R8 simultaneous increments", v, mk(5, 0, 4, 0));
  endtask

  task automatic t_buf_wrap;
    logic [RW-1:0] v;
    for (int i = 0; i < 33; i++) step(1, 0, 0, 0);
    do_read(v);
    check("R4 buffer wrap and flag", v, mk(1, 1, 0, 0));
    do_read(v);
    check("R4 flag cleared by read", v, '0);
  endtask

  task automatic t_ovf_wrap;
    logic [RW-1:0] v;
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    do_read(v);
    check("R5 overflow wrap and sticky flag", v, mk(0, 0, 1, 1));
    check("R9 reserved bits zero", v >> (BW + OW + 2), '0);
  endtask

  task automatic t_read_inc;
    logic [RW-1:0] v;
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0);
    step(1, 0, 1, 1);
    check("R7 read returns old value", rd_data, mk(3, 0, 3, 0));
    do_read(v);
    check("R7 count is one after read", v, mk(1, 0, 1, 0));
  endtask

  task automatic t_hold;
    logic [RW-1:0] v;
    step(1, 0, 0, 0);
    do_read(v);
    for (int i = 0; i < 6; i++) step(1, 1, 1, 0);
    check("R10 rd_data holds without read", rd_data, mk(1, 0, 0, 0));
    do_read(v);
    check("R10 pending counts", v, mk(6, 0, 6, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_buf_count();
    t_ovf_runt();
    t_both();
    t_buf_wrap();
    t_ovf_wrap();
    t_read_inc();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule